// File: doc/BRIEF.md
# Matrix Keypad Row-Column Scanner

This block reads a 4x4 key matrix whose row and column lines are pulled up to logic 1. It pulls one row low at a time, in a fixed rotating order, and listens on the four column lines. A pressed key joins its row to its column, so the column that belongs to that key reads low while its row is the one being driven. The block works out which key is down, debounces the result over several full scans, and reports the key as an 8-bit pattern meant to drive eight indicator LEDs directly.

The pattern holds two one-hot nibbles. The upper nibble names the row and the lower nibble names the column. The most significant bit of each nibble stands for the first row or the first column. With no key down the pattern is all zeros. When a newly debounced key is accepted, a single-cycle strobe marks the moment the pattern takes its new value. The pattern then stays put until the keypad has read empty for the same number of scans. Keys are counted 1 to 16 along each row and then down the rows. So key 1 reads `1000_1000`, key 6 reads `0100_0100`, key 12 reads `0010_0001` and key 16 reads `0001_0001`.

Top module: `kpad_scanner`

## Requirements
- R1: Exactly one of `rowOut[3:0]` is low at any time, with bit 0 driving row 1. The low line moves row 1 → 2 → 3 → 4 → 1, and each row stays low for `SLOT_CYCLES` clock cycles.
- R2: An accepted key on row r (1..4) and column c (1..4) gives `keyCode[8-r] = 1` and `keyCode[4-c] = 1`, with all other bits 0. Key number n = 4·(r−1)+c, and `colIn[c-1]` is column c.
- R3: While no key is pressed, `keyCode` stays `8'h00` and `keyValid` stays low.
- R4: A row sample in which two or more columns read low is ignored, and no key is reported from it.
- R5: If single-column hits appear on more than one row within one scan, the lowest-numbered row's key is the one taken.
- R6: A key is accepted only after the same scan result has been seen on `STABLE_SCANS` consecutive full scans. A shorter press is never reported.
- R7: `keyValid` pulses high for exactly one cycle per accepted key, in the same cycle that `keyCode` first shows that key. It never pulses at any other time.
- R8: Once a key is accepted, `keyCode` holds its value while any key remains down, including when a different key replaces it, and no new pulse fires.
- R9: A held code clears to `8'h00` only after `STABLE_SCANS` consecutive empty scans. After that, a fresh press is accepted again.
- R10: A synchronous active-high `rst` clears `keyCode` and `keyValid`, selects row 1 (`rowOut = 4'b1110`) and clears the debounce history.
- R11: The pulse for a steady press arrives no sooner than `STABLE_SCANS−1` scans and no later than `STABLE_SCANS+1` scans plus one slot after the press starts. A scan is `4·SLOT_CYCLES` cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| colIn | input | 4 | Column lines from the keypad, pulled high, low when joined to the driven row |
| rowOut | output | 4 | Row drive lines, exactly one low |
| keyCode | output | 8 | Row one-hot nibble in bits 7..4, column one-hot nibble in bits 3..0, zero when idle |
| keyValid | output | 1 | One-cycle strobe when a new key is accepted |

## Verification
A bad slot counter or row pointer shows on `rowOut` within one slot, either as a skipped row or as a slot of the wrong length. A wrong field mapping or a mangled scan result shows as a wrong `keyCode` value in the very cycle of the pulse. Debounce faults show as latency: a counter that compares badly or is not cleared fires the strobe too early or fires it twice, so the acceptance window is checked against the press time. A hold register that fails to stick shows as a code that changes between two nonzero values, or as a second strobe within a few scans.

// File: rtl/kpad_pkg.sv
package kpad_pkg;

  localparam int NUM_ROWS  = 4;
  localparam int NUM_COLS  = 4;
  localparam int CODE_W    = NUM_ROWS + NUM_COLS;
  localparam int ROW_IDX_W = $clog2(NUM_ROWS);

  typedef logic [CODE_W-1:0] code_t;

  // Strobes handed from the scan control to the datapath.
  typedef struct packed {
    logic                 sampleNow;  // last cycle of the current row slot
    logic                 scanDone;   // sampleNow on the final row of a scan
    logic [ROW_IDX_W-1:0] rowIdx;     // row currently driven low (0 = row 1)
  } ctrl_t;

  // True when exactly one bit of the column-low vector is set.
  function automatic logic singleLow(input logic [NUM_COLS-1:0] v);
    int n;
    n = 0;
    for (int i = 0; i < NUM_COLS; i++) begin
      if (v[i]) n++;
    end
    return (n == 1);
  endfunction

endpackage

// File: rtl/kpad_sync.sv
module kpad_sync #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stage1;
  logic [WIDTH-1:0] stage2;

  // Idle level of a pulled-up line is 1, so reset to all ones.
  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '1;
      stage2 <= '1;
    end else begin
      stage1 <= asyncIn;
      stage2 <= stage1;
    end
  end

  assign syncOut = stage2;

endmodule

// File: rtl/kpad_ctrl.sv
module kpad_ctrl
  import kpad_pkg::*;
#(
  parameter int SLOT_CYCLES = 50000
) (
  input  logic                clk,
  input  logic                rst,
  output ctrl_t               ctrl,
  output logic [NUM_ROWS-1:0] rowOut
);

  localparam int SLOT_W = (SLOT_CYCLES > 1) ? $clog2(SLOT_CYCLES) : 1;
  localparam logic [SLOT_W-1:0]    SLOT_LAST = SLOT_W'(SLOT_CYCLES - 1);
  localparam logic [ROW_IDX_W-1:0] ROW_LAST  = ROW_IDX_W'(NUM_ROWS - 1);

  logic [SLOT_W-1:0]    slotCnt;
  logic [ROW_IDX_W-1:0] rowIdx;
  logic                 slotEnd;

  assign slotEnd = (slotCnt == SLOT_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      slotCnt <= '0;
      rowIdx  <= '0;
    end else if (slotEnd) begin
      slotCnt <= '0;
      rowIdx  <= (rowIdx == ROW_LAST) ? '0 : rowIdx + ROW_IDX_W'(1);
    end else begin
      slotCnt <= slotCnt + SLOT_W'(1);
    end
  end

  always_comb begin
    ctrl.sampleNow = slotEnd;
    ctrl.scanDone  = slotEnd && (rowIdx == ROW_LAST);
    ctrl.rowIdx    = rowIdx;
  end

  // Active-low row drive: only the selected row is pulled down.
  for (genvar r = 0; r < NUM_ROWS; r++) begin : g_rowDrive
    assign rowOut[r] = (rowIdx != ROW_IDX_W'(r));
  end

endmodule

// File: rtl/kpad_datapath.sv
module kpad_datapath
  import kpad_pkg::*;
#(
  parameter int STABLE_SCANS = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  ctrl_t               ctrl,
  input  logic [NUM_COLS-1:0] colSync,
  output code_t               keyCode,
  output logic                keyValid
);

  localparam int CNT_W = $clog2(STABLE_SCANS + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(STABLE_SCANS);

  logic [NUM_COLS-1:0] colLow;
  logic [NUM_COLS-1:0] colField;
  logic [NUM_ROWS-1:0] rowField;

  code_t rowCode;    // result of the row being sampled now
  code_t candCode;   // first valid hit earlier in this scan
  code_t scanCode;   // result of the whole scan, valid on scanDone
  code_t lastCode;   // previous scan result
  code_t heldCode;   // reported key

  logic [CNT_W-1:0] stableCnt;
  logic [CNT_W-1:0] nextCnt;
  logic             accept;
  logic             dropKey;

  assign colLow = ~colSync;

  // Column 1 lands on the top bit of the column nibble.
  for (genvar c = 0; c < NUM_COLS; c++) begin : g_colField
    assign colField[NUM_COLS-1-c] = colLow[c];
  end

  // Row 1 lands on the top bit of the row nibble.
  for (genvar r = 0; r < NUM_ROWS; r++) begin : g_rowField
    assign rowField[NUM_ROWS-1-r] = (ctrl.rowIdx == ROW_IDX_W'(r));
  end

  // Zero or several low columns give no hit for this row.
  always_comb begin
    rowCode = singleLow(colLow) ? {rowField, colField} : '0;
  end

  // Earlier rows in the scan take priority over later ones.
  always_comb begin
    scanCode = (candCode != '0) ? candCode : rowCode;
  end

  always_comb begin
    if (scanCode == lastCode) begin
      nextCnt = (stableCnt == CNT_FULL) ? stableCnt : stableCnt + CNT_W'(1);
    end else begin
      nextCnt = CNT_W'(1);
    end
  end

  assign accept  = ctrl.scanDone && (nextCnt == CNT_FULL) &&
                   (scanCode != '0) && (heldCode == '0);
  assign dropKey = ctrl.scanDone && (nextCnt == CNT_FULL) &&
                   (scanCode == '0) && (heldCode != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      candCode <= '0;
    end else if (ctrl.scanDone) begin
      candCode <= '0;
    end else if (ctrl.sampleNow && (candCode == '0)) begin
      candCode <= rowCode;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lastCode  <= '0;
      stableCnt <= '0;
    end else if (ctrl.scanDone) begin
      lastCode  <= scanCode;
      stableCnt <= nextCnt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      heldCode <= '0;
      keyValid <= 1'b0;
    end else begin
      keyValid <= accept;
      if (accept) begin
        heldCode <= scanCode;
      end else if (dropKey) begin
        heldCode <= '0;
      end
    end
  end

  assign keyCode = heldCode;

endmodule

// File: rtl/kpad_scanner.sv
module kpad_scanner
  import kpad_pkg::*;
#(
  parameter int SLOT_CYCLES  = 50000,
  parameter int STABLE_SCANS = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] colIn,
  output logic [3:0] rowOut,
  output logic [7:0] keyCode,
  output logic       keyValid
);

  ctrl_t               ctrl;
  logic [NUM_COLS-1:0] colSync;

  kpad_sync #(
    .WIDTH(NUM_COLS)
  ) u_sync (
    .clk    (clk),
    .rst    (rst),
    .asyncIn(colIn),
    .syncOut(colSync)
  );

  kpad_ctrl #(
    .SLOT_CYCLES(SLOT_CYCLES)
  ) u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .ctrl  (ctrl),
    .rowOut(rowOut)
  );

  kpad_datapath #(
    .STABLE_SCANS(STABLE_SCANS)
  ) u_dp (
    .clk     (clk),
    .rst     (rst),
    .ctrl    (ctrl),
    .colSync (colSync),
    .keyCode (keyCode),
    .keyValid(keyValid)
  );

endmodule

// File: rtl/kpad_scanner_chk.sv
module kpad_scanner_chk #(
  parameter int SLOT_CYCLES = 50000
) (
  input logic       clk,
  input logic       rst,
  input logic [3:0] rowOut,
  input logic [7:0] keyCode,
  input logic       keyValid
);

  localparam int RUN_W = $clog2(SLOT_CYCLES + 2) + 1;
  localparam logic [RUN_W-1:0] RUN_CAP = RUN_W'(SLOT_CYCLES + 1);

  logic             primed = 1'b0;
  logic [3:0]       lastRow;
  logic [RUN_W-1:0] runLen;

  always_ff @(posedge clk) begin
    primed  <= 1'b1;
    lastRow <= rowOut;
    if (rst) begin
      runLen <= '0;
    end else if (rowOut != lastRow) begin
      runLen <= '0;
    end else if (runLen < RUN_CAP) begin
      runLen <= runLen + RUN_W'(1);
    end
  end

  // R1: one row low at a time
  a_r1_single_row_low: assert property (@(posedge clk) disable iff (rst)
    $countones(rowOut) == 3);

  // R1: low line advances to the next row only
  a_r1_row_rotates: assert property (@(posedge clk) disable iff (rst)
    (rowOut != lastRow) |-> (rowOut == {lastRow[2:0], lastRow[3]}));

  // R1: slot length at each row change
  a_r1_slot_length: assert property (@(posedge clk) disable iff (rst)
    (rowOut != lastRow) |->
      (runLen >= RUN_W'(SLOT_CYCLES - 1) && runLen <= RUN_W'(SLOT_CYCLES)));

  // R2: code is zero or one bit per nibble
  a_r2_code_shape: assert property (@(posedge clk) disable iff (rst)
    (keyCode == 8'h00) ||
    ($countones(keyCode[7:4]) == 1 && $countones(keyCode[3:0]) == 1));

  // R7: pulse carries a key
  a_r7_pulse_has_code: assert property (@(posedge clk) disable iff (rst)
    keyValid |-> (keyCode != 8'h00));

  // R7: pulse lasts a single cycle
  a_r7_pulse_one_cycle: assert property (@(posedge clk) disable iff (rst)
    keyValid |=> !keyValid);

  // R7: pulse only when code leaves zero
  a_r7_pulse_from_empty: assert property (@(posedge clk) disable iff (rst)
    keyValid |-> ($past(keyCode) == 8'h00));

  // R7: code never appears without its pulse
  a_r7_new_code_pulses: assert property (@(posedge clk) disable iff (rst)
    (($past(keyCode) == 8'h00) && (keyCode != 8'h00)) |-> keyValid);

  // R8: code never jumps between two keys
  a_r8_no_direct_swap: assert property (@(posedge clk) disable iff (rst)
    !$stable(keyCode) |-> (($past(keyCode) == 8'h00) || (keyCode == 8'h00)));

  // R10: state after a reset cycle
  a_r10_reset_state: assert property (@(posedge clk)
    (primed && $past(rst)) |->
      (keyCode == 8'h00 && !keyValid && rowOut == 4'b1110));

endmodule

bind kpad_scanner kpad_scanner_chk #(
  .SLOT_CYCLES(SLOT_CYCLES)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .rowOut  (rowOut),
  .keyCode (keyCode),
  .keyValid(keyValid)
);

// File: tb/sim_kpad_scanner.sv
module sim_kpad_scanner;

  localparam int SLOT   = 8;
  localparam int STABLE = 3;
  localparam int SCAN   = 4 * SLOT;
  localparam int LAT_LO = (STABLE - 1) * SCAN;
  localparam int LAT_HI = (STABLE + 1) * SCAN + SLOT;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] colIn;
  logic [3:0] rowOut;
  logic [7:0] keyCode;
  logic       keyValid;

  logic [15:0] keys = '0;  // bit n-1 = key n pressed

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int pulses = 0;
  int lastPulseCyc = 0;
  bit finished = 0;
  logic [7:0] expQ[$];

  always #10 clk = ~clk;

  kpad_scanner #(
    .SLOT_CYCLES (SLOT),
    .STABLE_SCANS(STABLE)
  ) u0 (
    .clk     (clk),
    .rst     (rst),
    .colIn   (colIn),
    .rowOut  (rowOut),
    .keyCode (keyCode),
    .keyValid(keyValid)
  );

  // Keypad model: pressed key joins its row to its column, pull-ups elsewhere.
  always_comb begin
    colIn = 4'hF;
    for (int r = 0; r < 4; r++) begin
      for (int c = 0; c < 4; c++) begin
        if (keys[r*4+c] && (rowOut[r] == 1'b0)) colIn[c] = 1'b0;
      end
    end
  end

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input logic ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  function automatic logic [7:0] codeOf(input int n);
    int r, c;
    r = (n - 1) / 4;
    c = (n - 1) % 4;
    return (8'h80 >> r) | (8'h08 >> c);
  endfunction

  // Monitor: compare every pulse against the scoreboard queue.
  always @(negedge clk) begin
    if (!rst && keyValid) begin
      pulses++;
      lastPulseCyc = cyc;
      if (expQ.size() == 0) begin
        check(1'b0, "R7 unexpected pulse", {24'h0, keyCode}, 32'h0);
      end else begin
        logic [7:0] e;
        e = expQ.pop_front();
        check(keyCode == e, "R2 code on pulse", {24'h0, keyCode}, {24'h0, e});
      end
    end
  end

  // Driver: press keys, queue the expected code, wait for the pulse.
  task automatic pressExpect(input logic [15:0] mask, input logic [7:0] exp,
                             input string tag);
    int t0, n0, lat;
    bit got;
    keys = mask;
    t0 = cyc;
    n0 = pulses;
    expQ.push_back(exp);
    got = 0;
    for (int i = 0; i < LAT_HI + 16 && !got; i++) begin
      @(negedge clk);
      if (pulses > n0) got = 1;
    end
    check(got, tag, pulses - n0, 1);
    if (got) begin
      lat = lastPulseCyc - t0;
      check(lat >= LAT_LO && lat <= LAT_HI, "R11 pulse latency", lat, LAT_HI);
    end else begin
      void'(expQ.pop_back());
    end
  endtask

  task automatic releaseClear();
    keys = '0;
    repeat ((STABLE + 2) * SCAN) @(negedge clk);
    check(keyCode == 8'h00, "R9 release clears code", keyCode, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R11 watchdog expired actual=%0d expected=done", cyc);
    report();
  end

  initial begin
    int bad;
    int n0;
    // R10: reset state
    repeat (4) @(negedge clk);
    check(keyCode == 8'h00 && !keyValid, "R10 outputs in reset", {keyValid, keyCode}, 0);
    check(rowOut == 4'b1110, "R10 row 1 in reset", rowOut, 4'b1110);
    rst = 1'b0;

    // R1: exact rotation and slot length
    bad = 0;
    for (int k = 1; k <= 3 * SCAN; k++) begin
      logic [3:0] e;
      @(negedge clk);
      e = ~(4'b0001 << ((k / SLOT) % 4));
      if (rowOut != e) bad++;
    end
    check(bad == 0, "R1 row rotation", bad, 0);

    // R3: idle keypad
    n0 = pulses;
    repeat (6 * SCAN) @(negedge clk);
    check(keyCode == 8'h00 && pulses == n0, "R3 idle stays zero", keyCode, 0);

    // R2: the four worked examples with literal codes
    pressExpect(16'h0001, 8'h88, "R2 key 1");
    // R8: held while pressed
    repeat (4 * SCAN) @(negedge clk);
    check(keyCode == 8'h88, "R8 code holds", keyCode, 8'h88);
    // R9: short release bounce keeps the code
    keys = '0;
    repeat (20) @(negedge clk);
    keys = 16'h0001;
    repeat (4 * SCAN) @(negedge clk);
    check(keyCode == 8'h88, "R9 short release ignored", keyCode, 8'h88);
    releaseClear();
    pressExpect(16'h0020, 8'h44, "R2 key 6");
    releaseClear();
    pressExpect(16'h0800, 8'h21, "R2 key 12");
    releaseClear();
    pressExpect(16'h8000, 8'h11, "R2 key 16");
    releaseClear();

    // R2: every key in row-major order
    for (int n = 1; n <= 16; n++) begin
      pressExpect(16'h0001 << (n - 1), codeOf(n), "R2 row-major key");
      releaseClear();
    end

    // R6: press shorter than one scan
    n0 = pulses;
    keys = 16'h0004;
    repeat (20) @(negedge clk);
    keys = '0;
    repeat (6 * SCAN) @(negedge clk);
    check(keyCode == 8'h00 && pulses == n0, "R6 short press rejected", keyCode, 0);

    // R4: two columns low in one row
    n0 = pulses;
    keys = 16'h0030;
    repeat (6 * SCAN) @(negedge clk);
    check(keyCode == 8'h00 && pulses == n0, "R4 multi-column ignored", keyCode, 0);
    releaseClear();

    // R5: hits on rows 2 and 3, row 2 wins
    pressExpect(16'h0240, 8'h42, "R5 lowest row wins");
    releaseClear();

    // R8: a different key replaces the held one
    pressExpect(16'h0001, 8'h88, "R8 first key");
    n0 = pulses;
    keys = 16'h8000;
    repeat (6 * SCAN) @(negedge clk);
    check(keyCode == 8'h88 && pulses == n0, "R8 swap keeps code", keyCode, 8'h88);
    releaseClear();

    // R10: reset while a key is held, then re-acceptance
    pressExpect(16'h0100, 8'h28, "R10 key 9 before reset");
    repeat (SCAN) @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(keyCode == 8'h00 && !keyValid, "R10 reset clears code", keyCode, 0);
    check(rowOut == 4'b1110, "R10 reset selects row 1", rowOut, 4'b1110);
    rst = 1'b0;
    pressExpect(16'h0100, 8'h28, "R10 re-accept after reset");
    releaseClear();

    // R7: every queued expectation consumed
    check(expQ.size() == 0, "R7 no missing pulses", expQ.size(), 0);
    report();
  end

endmodule